// File: doc/BRIEF.md
# Ternary Weight Quantizer with Mean-Magnitude Threshold

The block turns a stream of signed fixed-point weights into ternary codes. It handles one group at a time, in two passes. While a group streams in, each weight goes into an internal buffer and its magnitude is added to a running total. When the group closes, the total is shifted right by log2 of the group size to give the mean magnitude, and a small constant is added to it. This sum is the group's scale denominator. The scale factor is its reciprocal.

In the second pass the block classifies every buffered weight without a divider. It compares twice the weight's magnitude with the denominator. This is the same as comparing the scaled weight with one half. Weights above the band become +1, weights below its negation become -1, and everything else becomes 0. The 2-bit codes are packed sixteen to a 32-bit word and streamed out with a last flag. Both sides use valid/ready handshakes. A new group is held off until every word of the current group has been taken.

Top module: `tern_absmean_quant`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: The codes are 2'b00 for zero, 2'b01 for +1 and 2'b11 for -1. The code 2'b10 never appears in an output word.
- R3: out_mag equals (sum of |w| over the group >> log2(GROUP)) + EPS. Weights missing from a short group count as zero. out_mag stays constant across all words of a group.
- R4: A weight w gets +1 when 2w > out_mag and -1 when -2w > out_mag. It gets 0 otherwise, which includes the cases 2|w| = out_mag.
- R5: The code of weight i (counting from 0 in arrival order) sits in bits [2(i mod 16)+1 : 2(i mod 16)] of output word i/16. Words leave in increasing order.
- R6: A group ends at the weight that carries in_last, or at the GROUP-th weight, whichever comes first. A group of n weights yields ceil(n/16) words, and out_last is set only on the final word. The code slots of that word past weight n-1 are 2'b00.
- R7: out_valid is 1 in the cycle after the group's final weight is accepted. Each following word is valid in the cycle after the previous word is accepted.
- R8: in_ready is 0 from the acceptance of a group's final weight until its last word is accepted. in_ready is 1 again in the next cycle.
- R9: While out_valid is 1 and out_ready is 0, out_word, out_last and out_mag hold their values.
- R10: The most negative weight, -2^(W_WIDTH-1), is quantized correctly, including in a group made entirely of that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Weight on in_weight is valid |
| in_ready | output | 1 | Block accepts a weight this cycle |
| in_weight | input | W_WIDTH | Signed two's-complement weight |
| in_last | input | 1 | Marks the final weight of a group |
| out_valid | output | 1 | Packed code word is valid |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 32 | Sixteen 2-bit codes, weight order LSB first |
| out_last | output | 1 | Final word of the group |
| out_mag | output | W_WIDTH+1 | Mean magnitude plus EPS (scale denominator) |

## Verification
The first code word of a group is due in the cycle after the final weight is accepted. Each later word is due in the cycle after its predecessor is taken. The bench therefore samples at the falling edge that directly follows each of those rising edges, and checks that out_valid is already high there with no wait loop. In the same falling-edge samples it checks that in_ready is low during the drain and high again one cycle after the last word. Stalled words are sampled at two consecutive falling edges to confirm they hold. Expected codes and the denominator are worked out with integer arithmetic in the bench. The stimulus covers every constant-valued group, ramp patterns with short and full lengths, and a group built so that some weights land exactly on the band edge.

// File: rtl/tq_pkg.sv
package tq_pkg;
    // Ternary code encoding; 2'b10 is never produced.
    typedef enum logic [1:0] {
        TQ_ZERO = 2'b00,
        TQ_POS  = 2'b01,
        TQ_NEG  = 2'b11
    } tq_code_e;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_EMIT = 1'b1
    } tq_phase_e;

    localparam int TQ_CPW     = 16;          // codes per output word
    localparam int TQ_LOG2CPW = 4;
    localparam int TQ_WORD_W  = 2 * TQ_CPW;  // 32-bit output word
endpackage

// File: rtl/tq_abs_accum.sv
module tq_abs_accum #(
    parameter int W_WIDTH = 16,
    parameter int LOG2G   = 6,
    localparam int SUM_W  = W_WIDTH + LOG2G
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      en,
    input  logic signed [W_WIDTH-1:0] din,
    output logic [SUM_W-1:0]          sum_q,
    output logic [SUM_W-1:0]          sum_nx
);
    logic [SUM_W-1:0]   sum_d;
    logic [W_WIDTH:0]   mag_w;
    logic signed [W_WIDTH:0] ext_w;

    always_comb begin
        ext_w = {din[W_WIDTH-1], din};
        mag_w = ext_w[W_WIDTH] ? W_WIDTH'(0) - ext_w : ext_w;
        sum_d = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (en) begin
            sum_d = sum_q + SUM_W'(mag_w);
        end
        sum_nx = sum_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    // R10: the magnitude total never wraps while a group is collected
    p_sum_grows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (sum_q >= $past(sum_q)));
endmodule

// File: rtl/tq_classify.sv
module tq_classify
    import tq_pkg::*;
#(
    parameter int W_WIDTH = 16,
    localparam int MAG_W  = W_WIDTH + 1
) (
    input  logic signed [W_WIDTH-1:0] w,
    input  logic [MAG_W-1:0]          mag,
    input  logic                      live,
    output tq_code_e                  code
);
    logic signed [W_WIDTH:0] ext_w;
    logic [W_WIDTH:0]        abs_w;
    logic [W_WIDTH+1:0]      dbl_w;
    logic [W_WIDTH+1:0]      mag_x;

    always_comb begin
        ext_w = {w[W_WIDTH-1], w};
        abs_w = ext_w[W_WIDTH] ? (W_WIDTH+1)'(0) - ext_w : ext_w;
        dbl_w = {abs_w, 1'b0};
        mag_x = {1'b0, mag};
        code  = TQ_ZERO;
        if (live && (dbl_w > mag_x)) begin
            code = w[W_WIDTH-1] ? TQ_NEG : TQ_POS;
        end
    end
endmodule

// File: rtl/tq_packer.sv
module tq_packer
    import tq_pkg::*;
#(
    parameter int W_WIDTH = 16,
    localparam int MAG_W  = W_WIDTH + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          chk_en,
    input  logic [TQ_CPW*W_WIDTH-1:0]     slots,
    input  logic [TQ_CPW-1:0]             live,
    input  logic [MAG_W-1:0]              mag,
    output logic [TQ_WORD_W-1:0]          word
);
    for (genvar j = 0; j < TQ_CPW; j++) begin : g_lane
        tq_code_e lane_code;

        tq_classify #(.W_WIDTH(W_WIDTH)) u_cls (
            .w    (slots[j*W_WIDTH +: W_WIDTH]),
            .mag  (mag),
            .live (live[j]),
            .code (lane_code)
        );

        assign word[2*j +: 2] = lane_code;

        // R2: the unused encoding never reaches the output word
        p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
            chk_en |-> (word[2*j +: 2] != 2'b10));

        // R6: slots past the end of the group are padded with zero
        p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (chk_en && !live[j]) |-> (word[2*j +: 2] == 2'b00));
    end
endmodule

// File: rtl/tern_absmean_quant.sv
module tern_absmean_quant
    import tq_pkg::*;
#(
    parameter int W_WIDTH = 16,
    parameter int GROUP   = 64,
    parameter int EPS     = 1,
    localparam int LOG2G  = $clog2(GROUP),
    localparam int MAG_W  = W_WIDTH + 1,
    localparam int SUM_W  = W_WIDTH + LOG2G,
    localparam int CNT_W  = LOG2G + 1,
    localparam int IDX_W  = CNT_W + TQ_LOG2CPW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic signed [W_WIDTH-1:0] in_weight,
    input  logic                      in_last,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [TQ_WORD_W-1:0]      out_word,
    output logic                      out_last,
    output logic [MAG_W-1:0]          out_mag
);
    typedef struct packed {
        tq_phase_e        ph;
        logic [CNT_W-1:0] cnt;   // weights held for the current group
        logic [CNT_W-1:0] widx;  // output word being offered
        logic [MAG_W-1:0] mag;   // mean magnitude plus EPS
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic signed [W_WIDTH-1:0] wbuf_q [GROUP];
    logic [SUM_W-1:0]          sum_q, sum_nx;
    logic                      take_in, take_out, drain_done;
    logic [CNT_W-1:0]          cnt_m1, last_widx;
    logic [TQ_CPW*W_WIDTH-1:0] slots;
    logic [TQ_CPW-1:0]         live;

    // ---------------- handshakes ----------------
    assign in_ready   = (ctl_q.ph == PH_FILL);
    assign out_valid  = (ctl_q.ph == PH_EMIT);
    assign take_in    = in_valid && in_ready;
    assign take_out   = out_valid && out_ready;
    assign cnt_m1     = ctl_q.cnt - CNT_W'(1);
    assign last_widx  = cnt_m1 >> TQ_LOG2CPW;
    assign out_last   = out_valid && (ctl_q.widx == last_widx);
    assign drain_done = take_out && out_last;
    assign out_mag    = ctl_q.mag;

    // ---------------- first pass: magnitude total ----------------
    tq_abs_accum #(.W_WIDTH(W_WIDTH), .LOG2G(LOG2G)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (drain_done),
        .en     (take_in),
        .din    (in_weight),
        .sum_q  (sum_q),
        .sum_nx (sum_nx)
    );

    always_ff @(posedge clk) begin
        if (take_in) wbuf_q[ctl_q.cnt[LOG2G-1:0]] <= in_weight;
    end

    // ---------------- control ----------------
    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.ph)
            PH_FILL: begin
                if (take_in) begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    if (in_last || (ctl_q.cnt == CNT_W'(GROUP - 1))) begin
                        ctl_d.ph   = PH_EMIT;
                        ctl_d.widx = '0;
                        ctl_d.mag  = MAG_W'(sum_nx >> LOG2G) + MAG_W'(EPS);
                    end
                end
            end
            PH_EMIT: begin
                if (drain_done) begin
                    ctl_d.ph   = PH_FILL;
                    ctl_d.cnt  = '0;
                    ctl_d.widx = '0;
                end else if (take_out) begin
                    ctl_d.widx = ctl_q.widx + CNT_W'(1);
                end
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_FILL, cnt: '0, widx: '0, mag: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // ---------------- second pass: fetch slots for one word ----------------
    for (genvar j = 0; j < TQ_CPW; j++) begin : g_fetch
        logic [IDX_W-1:0] idx;
        assign idx      = (IDX_W'(ctl_q.widx) << TQ_LOG2CPW) | IDX_W'(j);
        assign live[j]  = out_valid && (idx < IDX_W'(ctl_q.cnt));
        assign slots[j*W_WIDTH +: W_WIDTH] = live[j] ? wbuf_q[idx[LOG2G-1:0]] : '0;
    end

    tq_packer #(.W_WIDTH(W_WIDTH)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .chk_en (out_valid),
        .slots  (slots),
        .live   (live),
        .mag    (ctl_q.mag),
        .word   (out_word)
    );

    // ---------------- assertions ----------------
    // R9: a stalled word holds all its outputs
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)
                                       && $stable(out_last) && $stable(out_mag)));

    // R8: no weight is taken while a group drains
    p_no_fill_in_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R3: the denominator stays fixed across the words of a group
    p_mag_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !drain_done) |=> $stable(out_mag));

    // R6: the held count never exceeds the group size
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= CNT_W'(GROUP));

    // R7: the final accepted weight opens the drain in the next cycle
    p_emit_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_in && in_last) |=> out_valid);
endmodule

// File: tb/tb_tern_absmean_quant.sv
module tb_tern_absmean_quant;
    localparam int W     = 6;
    localparam int GROUP = 32;
    localparam int EPS   = 1;
    localparam int LOG2G = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic signed [W-1:0] in_weight = '0;
    logic in_ready, out_valid, out_last;
    logic [31:0] out_word;
    logic [W:0]  out_mag;

    int vectors = 0;
    int fails = 0;
    int gw [GROUP];
    int cyc = 0;

    always #5 clk = ~clk;

    tern_absmean_quant #(.W_WIDTH(W), .GROUP(GROUP), .EPS(EPS)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_weight(in_weight), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_last(out_last), .out_mag(out_mag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    task automatic push(input int v, input bit last);
        @(negedge clk);
        in_valid  = 1'b1;
        in_weight = W'(v);
        in_last   = last;
        @(posedge clk);
        #1 in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    function automatic logic [1:0] exp_code(input int v, input int mag);
        if (2 * v > mag)  return 2'b01;   // R4 positive, R2 encoding
        if (-2 * v > mag) return 2'b11;   // R4 negative
        return 2'b00;                     // R4 band incl. equality
    endfunction

    task automatic run_group(input int len, input bit stall);
        int sum = 0;
        int mag;
        int nw;
        logic [31:0] held;
        for (int i = 0; i < len; i++) begin
            sum += (gw[i] < 0) ? -gw[i] : gw[i];
            push(gw[i], i == len - 1);
        end
        mag = (sum >> LOG2G) + EPS;
        nw  = (len + 15) / 16;
        for (int k = 0; k < nw; k++) begin
            logic [31:0] ew = '0;
            for (int j = 0; j < 16; j++)
                if (k * 16 + j < len) ew[2*j +: 2] = exp_code(gw[k*16+j], mag);
            @(negedge clk);
            chk(out_valid == 1'b1, "R7 word valid on time", 32'(out_valid), 1);
            chk(in_ready == 1'b0, "R8 input held off in drain", 32'(in_ready), 0);
            if (stall && (k % 2 == 0)) begin
                held = out_word;
                @(negedge clk);
                chk(out_valid && out_word == held, "R9 stalled word held", out_word, held);
            end
            chk(out_word == ew, "R4/R5/R6 code word", out_word, ew);
            chk(out_last == (k == nw - 1), "R6 last flag", 32'(out_last), 32'(k == nw - 1));
            chk(32'(out_mag) == 32'(mag), "R3 denominator", 32'(out_mag), 32'(mag));
            out_ready = 1'b1;
            @(posedge clk);
            #1 out_ready = 1'b0;
        end
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R8 ready after drain",
            {30'd0, in_ready, out_valid}, 32'h2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state",
            {30'd0, in_ready, out_valid}, 32'h2);

        // Constant groups over every weight value; includes -32 (R10)
        for (int v = -32; v < 32; v++) begin
            for (int i = 0; i < GROUP; i++) gw[i] = v;
            run_group(GROUP, v[0]);
        end

        // Ramp patterns, some short groups ending on in_last (R5, R6)
        for (int s = 0; s < 64; s++) begin
            int len = (s % 5 == 0) ? (s % 32) + 1 : GROUP;
            for (int i = 0; i < GROUP; i++) gw[i] = ((i * s + s * 7 + 3) % 64) - 32;
            run_group(len, s[1]);
        end

        // Band edge: out_mag = 10, so |w| = 5 gives 0 and |w| = 6 gives +-1 (R4)
        gw[0] = 5; gw[1] = 6; gw[2] = -5; gw[3] = -6;
        for (int i = 4; i < GROUP; i++) gw[i] = (i % 2 == 0) ? 10 : -10;
        run_group(GROUP, 1'b1);

        // Full-scale negative single weight (R10)
        gw[0] = -32;
        run_group(1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule